// File: doc/BRIEF.md
# SD Host Command Gate and Slot Interrupt Glue

This block is the control-path glue that sits beside a generic SD host controller core. It decides whether the command the core holds may be sent to the card. The decision looks at the SD clock enable, at the power state, at an optional power-control override, at the data-line busy condition and at the command's own flags. The block also folds the core's normal and error interrupt status, their signal enables and the two card wake-up events into one level-sensitive slot interrupt.

The block owns a small set of control registers on a byte-addressable bus. That bus accepts 1-, 2- and 4-byte accesses, little-endian. The registers are: a clock control register, which sets the clock-stable flag itself on every write; a general control word, which selects power-controlled signalling and can mask buffer-port reads; a second control word with a fixed reset pattern; and a word that always reads zero. Reads of the buffer data port pass through from the core unless they are masked.

Command issue runs through a three-state machine. The states are `GS_IDLE`, `GS_GRANT` and `GS_REJECT`. The transition idle→grant or idle→reject is taken when `issue_req` is sampled high, and the choice depends on the issue rule. Each pulse state falls back to `GS_IDLE` when no request is present. A new request taken in a pulse state moves straight to the next grant or reject, without passing through idle.

Top module: `sdhc_ctl_glue`

## Requirements
- R1: A request sampled while bit 2 (SD clock enable) of the clock control register at offset 0x2C is 0 is rejected.
- R2: When `pwr_on` is 0, a request is rejected only if bit 12 or bit 3 of the general control word at offset 0x80 is set. When both bits are 0, power counts as present.
- R3: A command uses the data line when `cmd_flags` bit 5 is 1 or `cmd_flags[1:0]` is 2'b11. Such a command is rejected while `data_inhibit` or `xfer_stopped` is 1. A command that does not use the data line is unaffected by them.
- R4: A data-line command whose type field `cmd_flags[7:6]` is 2'b11 (abort) is granted despite `data_inhibit` or `xfer_stopped`, provided R1 and R2 pass.
- R5: A request sampled at a clock edge gives exactly one of `issue_grant` or `issue_reject`, high for one cycle after that edge. Both are low with no request.
- R6: `slot_irq` is high when any of the following holds: any bit of `nor_sts & nor_sig_en` is set; any bit of `err_sts & err_sig_en` is set; `nor_sts` bit 6 (card inserted) and `wake_en[1]` are both set; `nor_sts` bit 7 (card removed) and `wake_en[2]` are both set. Otherwise it is low.
- R7: On a write to the low byte of the clock control register, bit 3 (clock stable) is stored as 1 if the written bit 2 is 1 and `card_present` is 1, and as 0 in every other case.
- R8: When bit 6 of the general control word is set, reads at offset 0x20 (buffer data port) return 0. Otherwise they return `buf_rdata`.
- R9: After reset the general control word reads 0, the second control word at 0x84 reads 0x7F5F3F1F, and the word at 0x8C reads 0 at all times, including after writes to it.
- R10: `bus_size` selects the access width: 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes. A write changes only the addressed byte lanes, taking the value's low byte for the lowest address. Reads return the addressed bytes right-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address |
| bus_size | input | 2 | Access width code |
| bus_wdata | input | 32 | Write value, right-aligned |
| bus_rdata | output | 32 | Read value, right-aligned (combinational) |
| buf_rdata | input | 32 | Buffer port data from the core |
| card_present | input | 1 | Card detected |
| pwr_on | input | 1 | Bus power bit from the core |
| data_inhibit | input | 1 | Data line busy |
| xfer_stopped | input | 1 | Transfer paused |
| cmd_flags | input | 16 | Pending command flags |
| issue_req | input | 1 | Request to issue the pending command |
| issue_grant | output | 1 | One-cycle grant pulse |
| issue_reject | output | 1 | One-cycle reject pulse |
| nor_sts | input | 16 | Normal interrupt status |
| nor_sig_en | input | 16 | Normal interrupt signal enable |
| err_sts | input | 16 | Error interrupt status |
| err_sig_en | input | 16 | Error interrupt signal enable |
| wake_en | input | 3 | Wake-up control (bit 1 insert, bit 2 remove) |
| slot_irq | output | 1 | Slot interrupt level |

## Verification
A register write and an issue request can land on the same clock edge. The case that matters is a write that turns the SD clock enable on, or sets a power-override bit, in the cycle where a request is sampled. The bench provokes this by asserting `issue_req` together with `bus_wr` to the clock control register. The pulse that follows must reflect the register contents from before the edge, so a clock-enable write taken with a request still gives a reject, and the next request is granted.

// File: rtl/sdhc_glue_pkg.sv
package sdhc_glue_pkg;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam logic [AW-1:0] OFF_BUFPORT = 8'h20;
    localparam logic [AW-1:0] OFF_CLKCTL  = 8'h2C;
    localparam logic [AW-1:0] OFF_GCTL    = 8'h80;
    localparam logic [AW-1:0] OFF_GCTL2   = 8'h84;
    localparam logic [AW-1:0] OFF_ZERO    = 8'h8C;
    localparam logic [DW-1:0] GCTL2_RST   = 32'h7F5F3F1F;
    localparam int GC_PWRSEL_A = 12;
    localparam int GC_PWRSEL_B = 3;
    localparam int GC_BUFMASK  = 6;
    localparam int CK_SDEN     = 2;
    localparam int CK_STABLE   = 3;

    typedef enum logic [1:0] {
        GS_IDLE   = 2'd0,
        GS_GRANT  = 2'd1,
        GS_REJECT = 2'd2
    } gate_state_t;
endpackage

// File: rtl/sdhc_ctl_regs.sv
module sdhc_ctl_regs
    import sdhc_glue_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [1:0]    bus_size,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] buf_rdata,
    input  logic          card_present,
    output logic          sd_clk_on,
    output logic          pwr_sel,
    output logic [15:0]   clk_ctl_q
);
    localparam int NB = DW / 8;

    logic [DW-1:0] gctl_q, gctl2_q;
    logic [15:0]   clk_q;
    logic [2:0]    nbytes;

    always_comb begin
        unique case (bus_size)
            2'd0:    nbytes = 3'd1;
            2'd1:    nbytes = 3'd2;
            default: nbytes = 3'd4;
        endcase
    end

    function automatic logic [NB-1:0] lane_hits(input logic [AW-1:0] base,
                                                input logic [AW-1:0] a,
                                                input logic [2:0] n);
        logic [NB-1:0] m;
        for (int i = 0; i < NB; i++)
            m[i] = (a[AW-1:2] == base[AW-1:2]) && (i >= int'(a[1:0])) &&
                   (i < int'(a[1:0]) + int'(n));
        return m;
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                            input logic [NB-1:0] m,
                                            input logic [1:0] off,
                                            input logic [DW-1:0] wd);
        logic [DW-1:0] r;
        logic [DW-1:0] sh;
        r  = old;
        sh = wd << (8 * int'(off));
        for (int i = 0; i < NB; i++)
            if (m[i]) r[8*i +: 8] = sh[8*i +: 8];
        return r;
    endfunction

    logic [NB-1:0] hit_g, hit_g2, hit_ck;
    logic [DW-1:0] ck_new;
    assign hit_g  = bus_wr ? lane_hits(OFF_GCTL,   bus_addr, nbytes) : '0;
    assign hit_g2 = bus_wr ? lane_hits(OFF_GCTL2,  bus_addr, nbytes) : '0;
    assign hit_ck = bus_wr ? lane_hits(OFF_CLKCTL, bus_addr, nbytes) : '0;
    assign ck_new = merge({16'h0, clk_q}, hit_ck, bus_addr[1:0], bus_wdata);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gctl_q  <= '0;
            gctl2_q <= GCTL2_RST;
            clk_q   <= '0;
        end else begin
            gctl_q  <= merge(gctl_q,  hit_g,  bus_addr[1:0], bus_wdata);
            gctl2_q <= merge(gctl2_q, hit_g2, bus_addr[1:0], bus_wdata);
            if (|hit_ck[1:0]) begin
                clk_q <= ck_new[15:0];
                if (hit_ck[0])
                    clk_q[CK_STABLE] <= ck_new[CK_SDEN] & card_present;
            end
        end
    end

    logic [DW-1:0] word, shifted, sizemask;
    always_comb begin
        unique case (bus_addr[AW-1:2])
            OFF_BUFPORT[AW-1:2]: word = gctl_q[GC_BUFMASK] ? '0 : buf_rdata;
            OFF_CLKCTL[AW-1:2]:  word = {16'h0, clk_q};
            OFF_GCTL[AW-1:2]:    word = gctl_q;
            OFF_GCTL2[AW-1:2]:   word = gctl2_q;
            default:             word = '0;
        endcase
        shifted  = word >> (8 * int'(bus_addr[1:0]));
        unique case (bus_size)
            2'd0:    sizemask = 32'h0000_00FF;
            2'd1:    sizemask = 32'h0000_FFFF;
            default: sizemask = 32'hFFFF_FFFF;
        endcase
        bus_rdata = shifted & sizemask;
    end

    assign sd_clk_on = clk_q[CK_SDEN];
    assign pwr_sel   = gctl_q[GC_PWRSEL_A] | gctl_q[GC_PWRSEL_B];
    assign clk_ctl_q = clk_q;

    p_stable_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clk_q[CK_STABLE] |-> clk_q[CK_SDEN]);
    p_stable_needs_card_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hit_ck[0] && !card_present) |-> !clk_q[CK_STABLE]);
    p_zero_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[AW-1:2] == OFF_ZERO[AW-1:2]) |-> (bus_rdata == '0));
    p_buf_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gctl_q[GC_BUFMASK] && bus_addr[AW-1:2] == OFF_BUFPORT[AW-1:2]) |-> (bus_rdata == '0));
endmodule

// File: rtl/sdhc_issue_gate.sv
module sdhc_issue_gate
    import sdhc_glue_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        issue_req,
    input  logic        sd_clk_on,
    input  logic        pwr_on,
    input  logic        pwr_sel,
    input  logic        data_inhibit,
    input  logic        xfer_stopped,
    input  logic [15:0] cmd_flags,
    output logic        issue_grant,
    output logic        issue_reject
);
    gate_state_t state_q, state_d;
    logic uses_dat, is_abort, power_ok, line_ok, allowed;

    always_comb begin
        uses_dat = cmd_flags[5] || (cmd_flags[1:0] == 2'b11);
        is_abort = (cmd_flags[7:6] == 2'b11);
        power_ok = pwr_on || !pwr_sel;
        line_ok  = !((data_inhibit || xfer_stopped) && uses_dat && !is_abort);
        allowed  = sd_clk_on && power_ok && line_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = GS_IDLE;
        unique case (state_q)
            GS_IDLE, GS_GRANT, GS_REJECT:
                if (issue_req) state_d = allowed ? GS_GRANT : GS_REJECT;
            default: state_d = GS_IDLE;
        endcase
    end

    always_comb begin
        issue_grant  = 1'b0;
        issue_reject = 1'b0;
        unique case (state_q)
            GS_GRANT:  issue_grant  = 1'b1;
            GS_REJECT: issue_reject = 1'b1;
            default: ;
        endcase
    end

    p_one_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_req |=> (issue_grant ^ issue_reject));
    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_req |=> !(issue_grant || issue_reject));
    p_clk_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        issue_grant |-> $past(sd_clk_on));
    p_power_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_grant |-> !($past(!pwr_on) && $past(pwr_sel)));
    p_line_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_grant |-> !($past(data_inhibit || xfer_stopped) && $past(cmd_flags[5])
                          && $past(cmd_flags[7:6] != 2'b11)));
endmodule

// File: rtl/sdhc_irq_merge.sv
module sdhc_irq_merge #(
    parameter int SW = 16,
    parameter int INS_BIT = 6,
    parameter int REM_BIT = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] nor_sts,
    input  logic [SW-1:0] nor_sig_en,
    input  logic [SW-1:0] err_sts,
    input  logic [SW-1:0] err_sig_en,
    input  logic [2:0]    wake_en,
    output logic          slot_irq
);
    logic [3:0] term;
    always_comb begin
        term[0] = |(nor_sts & nor_sig_en);
        term[1] = |(err_sts & err_sig_en);
        term[2] = nor_sts[INS_BIT] & wake_en[1];
        term[3] = nor_sts[REM_BIT] & wake_en[2];
        slot_irq = |term;
    end

    p_err_raises_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(err_sts & err_sig_en)) |-> slot_irq);
    p_quiet_when_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (nor_sts == '0 && err_sts == '0) |-> !slot_irq);
endmodule

// File: rtl/sdhc_ctl_glue.sv
module sdhc_ctl_glue
    import sdhc_glue_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [7:0]    bus_addr,
    input  logic [1:0]    bus_size,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic [31:0]   buf_rdata,
    input  logic          card_present,
    input  logic          pwr_on,
    input  logic          data_inhibit,
    input  logic          xfer_stopped,
    input  logic [15:0]   cmd_flags,
    input  logic          issue_req,
    output logic          issue_grant,
    output logic          issue_reject,
    input  logic [15:0]   nor_sts,
    input  logic [15:0]   nor_sig_en,
    input  logic [15:0]   err_sts,
    input  logic [15:0]   err_sig_en,
    input  logic [2:0]    wake_en,
    output logic          slot_irq
);
    logic        sd_clk_on, pwr_sel;
    logic [15:0] clk_ctl_q;

    sdhc_ctl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .buf_rdata(buf_rdata), .card_present(card_present),
        .sd_clk_on(sd_clk_on), .pwr_sel(pwr_sel), .clk_ctl_q(clk_ctl_q)
    );

    sdhc_issue_gate u_gate (
        .clk(clk), .rst_n(rst_n), .issue_req(issue_req), .sd_clk_on(sd_clk_on),
        .pwr_on(pwr_on), .pwr_sel(pwr_sel), .data_inhibit(data_inhibit),
        .xfer_stopped(xfer_stopped), .cmd_flags(cmd_flags),
        .issue_grant(issue_grant), .issue_reject(issue_reject)
    );

    sdhc_irq_merge #(.SW(16)) u_irq (
        .clk(clk), .rst_n(rst_n), .nor_sts(nor_sts), .nor_sig_en(nor_sig_en),
        .err_sts(err_sts), .err_sig_en(err_sig_en), .wake_en(wake_en),
        .slot_irq(slot_irq)
    );

    p_stable_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clk_ctl_q[CK_STABLE] |-> sd_clk_on);
endmodule

// File: tb/sdhc_ctl_glue_tb.sv
`timescale 1ns/1ps
module sdhc_ctl_glue_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [1:0] bus_size = '0;
    logic [31:0] bus_wdata = '0, bus_rdata, buf_rdata = 32'hCAFE_F00D;
    logic card_present = 1'b0, pwr_on = 1'b0, data_inhibit = 1'b0, xfer_stopped = 1'b0;
    logic [15:0] cmd_flags = '0;
    logic issue_req = 1'b0, issue_grant, issue_reject;
    logic [15:0] nor_sts = '0, nor_sig_en = '0, err_sts = '0, err_sig_en = '0;
    logic [2:0] wake_en = '0;
    logic slot_irq;
    int n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    sdhc_ctl_glue dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = s;
        #1 d = bus_rdata;
    endtask

    // returns {grant, reject}
    task automatic issue(input logic [15:0] cf, output logic [1:0] res);
        @(negedge clk);
        cmd_flags = cf; issue_req = 1'b1;
        @(negedge clk);
        issue_req = 1'b0;
        res = {issue_grant, issue_reject};
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h80, 2'd2, v); chk("R9 gctl reset", v, 32'h0);
        rd(8'h84, 2'd2, v); chk("R9 gctl2 reset", v, 32'h7F5F3F1F);
        rd(8'h8C, 2'd2, v); chk("R9 zero word", v, 32'h0);
        chk("R5 idle pulses", {30'h0, issue_grant, issue_reject}, 32'h0);
        chk("R6 irq idle", {31'h0, slot_irq}, 32'h0);
    endtask

    task automatic t_lanes();
        logic [31:0] v;
        wr(8'h85, 2'd0, 32'hAA);
        rd(8'h84, 2'd2, v); chk("R10 byte write", v, 32'h7F5FAA1F);
        wr(8'h86, 2'd1, 32'h1234);
        rd(8'h84, 2'd2, v); chk("R10 half write", v, 32'h1234AA1F);
        rd(8'h87, 2'd0, v); chk("R10 byte read", v, 32'h12);
        rd(8'h86, 2'd1, v); chk("R10 half read", v, 32'h1234);
        wr(8'h8C, 2'd2, 32'hFFFFFFFF);
        rd(8'h8C, 2'd2, v); chk("R9 zero after write", v, 32'h0);
    endtask

    task automatic t_clock();
        logic [31:0] v;
        card_present = 1'b1;
        wr(8'h2C, 2'd1, 32'h0005);
        rd(8'h2C, 2'd1, v); chk("R7 stable set", v, 32'h000D);
        wr(8'h2C, 2'd1, 32'h0008);
        rd(8'h2C, 2'd1, v); chk("R7 stable forced off", v, 32'h0);
        card_present = 1'b0;
        wr(8'h2C, 2'd1, 32'h000D);
        rd(8'h2C, 2'd1, v); chk("R7 no card", v, 32'h0005);
        card_present = 1'b1;
        wr(8'h2C, 2'd1, 32'h0000);
    endtask

    task automatic t_issue();
        logic [1:0] r;
        issue(16'h0000, r); chk("R1 clock off reject", {30'h0, r}, 32'h1);
        // same edge: clock enable write and request; old state decides
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h2C; bus_size = 2'd1; bus_wdata = 32'h0004;
        issue_req = 1'b1; cmd_flags = 16'h0;
        @(negedge clk);
        bus_wr = 1'b0; issue_req = 1'b0;
        chk("R1 concurrent write", {30'h0, issue_grant, issue_reject}, 32'h1);
        issue(16'h0000, r); chk("R1 clock on grant", {30'h0, r}, 32'h2);
        pwr_on = 1'b0;
        issue(16'h0000, r); chk("R2 no override grant", {30'h0, r}, 32'h2);
        wr(8'h80, 2'd2, 32'h1000);
        issue(16'h0000, r); chk("R2 bit12 reject", {30'h0, r}, 32'h1);
        wr(8'h80, 2'd2, 32'h0008);
        issue(16'h0000, r); chk("R2 bit3 reject", {30'h0, r}, 32'h1);
        pwr_on = 1'b1;
        issue(16'h0000, r); chk("R2 power on grant", {30'h0, r}, 32'h2);
        wr(8'h80, 2'd2, 32'h0);
        data_inhibit = 1'b1;
        issue(16'h0020, r); chk("R3 data flag reject", {30'h0, r}, 32'h1);
        issue(16'h0003, r); chk("R3 busy resp reject", {30'h0, r}, 32'h1);
        issue(16'h0002, r); chk("R3 no data grant", {30'h0, r}, 32'h2);
        issue(16'h00E0, r); chk("R4 abort grant", {30'h0, r}, 32'h2);
        data_inhibit = 1'b0; xfer_stopped = 1'b1;
        issue(16'h0020, r); chk("R3 stopped reject", {30'h0, r}, 32'h1);
        issue(16'h00C3, r); chk("R4 abort stopped grant", {30'h0, r}, 32'h2);
        xfer_stopped = 1'b0;
        issue(16'h0020, r); chk("R3 idle line grant", {30'h0, r}, 32'h2);
        @(negedge clk);
        chk("R5 pulse one cycle", {30'h0, issue_grant, issue_reject}, 32'h0);
    endtask

    task automatic t_irq();
        @(negedge clk);
        nor_sts = 16'h0001; #1 chk("R6 nor no enable", {31'h0, slot_irq}, 32'h0);
        nor_sig_en = 16'h0001; #1 chk("R6 nor enabled", {31'h0, slot_irq}, 32'h1);
        nor_sts = 16'h0; err_sts = 16'h0010; #1 chk("R6 err no enable", {31'h0, slot_irq}, 32'h0);
        err_sig_en = 16'h0010; #1 chk("R6 err enabled", {31'h0, slot_irq}, 32'h1);
        err_sts = 16'h0; nor_sig_en = 16'h0; err_sig_en = 16'h0;
        nor_sts = 16'h0040; #1 chk("R6 insert no wake", {31'h0, slot_irq}, 32'h0);
        wake_en = 3'b010; #1 chk("R6 insert wake", {31'h0, slot_irq}, 32'h1);
        nor_sts = 16'h0080; #1 chk("R6 remove wrong wake", {31'h0, slot_irq}, 32'h0);
        wake_en = 3'b100; #1 chk("R6 remove wake", {31'h0, slot_irq}, 32'h1);
        nor_sts = 16'h0; wake_en = 3'b0;
    endtask

    task automatic t_buf();
        logic [31:0] v;
        rd(8'h20, 2'd2, v); chk("R8 passthrough", v, 32'hCAFE_F00D);
        wr(8'h80, 2'd0, 32'h40);
        rd(8'h20, 2'd2, v); chk("R8 masked", v, 32'h0);
        wr(8'h80, 2'd0, 32'h00);
        rd(8'h20, 2'd1, v); chk("R8 unmasked half", v, 32'hF00D);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lanes();
        t_clock();
        t_issue();
        t_irq();
        t_buf();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule